// File: doc/BRIEF.md
# Exhaustive Test Pattern Generator

This block produces the stimulus vectors for a combinational circuit under test with `WIDTH` inputs during built-in self-test. After a start pulse it emits every one of the 2^WIDTH input combinations exactly once, one per clock, with a valid strobe. A one-cycle done flag follows the last vector. The output then holds until the next start.

Two sources are available, chosen by the `mode` input when the run starts. Mode 0 is a binary up-counter. Mode 1 is a maximal-length autonomous shift register with exclusive-or feedback. Its feedback gets one extra correction term: whenever every bit except the top bit is zero, the feedback bit is inverted. This diverts the register through the all-zeros state, which a plain feedback register can never reach, so the sequence becomes complete.

The feedback taps come from a built-in table of primitive polynomials for widths 3 to 24. Elaboration rejects any other width, because exhaustive application is only practical for small input counts.

Top module: `exh_pattern_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `valid`=0 and `done`=0. `pattern` shows 0 if `mode`=0 (counter) and 1 (only bit 0 set) if `mode`=1 (shift register).
- R2: A `start` pulse while idle makes `valid` rise in the next cycle. The first pattern is 0 in mode 0 and 1 in mode 1.
- R3: In mode 0, each valid pattern equals the previous one plus 1. The run goes from 0 to all ones.
- R4: In mode 1, each valid pattern is the previous one shifted left by one place: new bits [WIDTH-1:1] equal old bits [WIDTH-2:0].
- R5: In mode 1, a run contains every WIDTH-bit value exactly once. The all-zeros pattern comes directly after the pattern with only the top bit set, and it is the last pattern of the run.
- R6: `valid` stays high for exactly 2^WIDTH consecutive cycles per run.
- R7: `done` is high for exactly one cycle, the cycle right after the last valid pattern. `valid` is low in that cycle.
- R8: Once a run ends, `pattern` holds its last value and `valid` stays low until the next `start`. A change of `mode` during this time does not alter `pattern`.
- R9: A `start` pulse during a run is ignored. The run neither restarts nor changes length.
- R10: `mode` is sampled only at start. A change of `mode` during a run does not change the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when idle |
| mode | input | 1 | 0 = binary counter, 1 = feedback shift register |
| pattern | output | WIDTH | Current test vector |
| valid | output | 1 | High while `pattern` is a vector of the run |
| done | output | 1 | One-cycle pulse after the last vector |

## Verification
The hardest case to reach is the pair of transitions the correction term creates in mode 1: from the top-bit-only state into all zeros, and from all zeros back to the seed. These happen only at the very end of a complete run, after 2^WIDTH-1 ordinary steps. The bench therefore drives complete runs at a width of 8. It records every emitted value in a 256-entry table, notes which value came just before zero, and confirms that zero closes the run. A second run changes `start` and `mode` partway through, to show that both are ignored until the run ends.

// File: rtl/epg_pkg.sv
package epg_pkg;

   localparam int unsigned EPG_MIN_W = 3;
   localparam int unsigned EPG_MAX_W = 24;

   typedef enum logic {
      GEN_COUNT = 1'b0,
      GEN_SHIFT = 1'b1
   } gen_mode_e;

   // Primitive feedback polynomials; bit k-1 set means stage k is tapped.
   function automatic logic [EPG_MAX_W-1:0] tap_mask(input int unsigned w);
      logic [EPG_MAX_W-1:0] m;
      m = '0;
      case (w)
         3:  m = 24'h000006;
         4:  m = 24'h00000C;
         5:  m = 24'h000014;
         6:  m = 24'h000030;
         7:  m = 24'h000060;
         8:  m = 24'h0000B8;
         9:  m = 24'h000110;
         10: m = 24'h000240;
         11: m = 24'h000500;
         12: m = 24'h000829;
         13: m = 24'h00100D;
         14: m = 24'h002015;
         15: m = 24'h006000;
         16: m = 24'h00D008;
         17: m = 24'h012000;
         18: m = 24'h020400;
         19: m = 24'h040023;
         20: m = 24'h090000;
         21: m = 24'h140000;
         22: m = 24'h300000;
         23: m = 24'h420000;
         24: m = 24'hE10000;
         default: m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/epg_shift_step.sv
module epg_shift_step
   import epg_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt
);

   localparam logic [EPG_MAX_W-1:0] TAP_ALL = tap_mask(WIDTH);
   localparam logic [WIDTH-1:0]     TAPS    = TAP_ALL[WIDTH-1:0];

   logic [WIDTH-1:0] tapped;
   logic             low_clear;
   logic             fb;

   for (genvar i = 0; i < WIDTH; i++) begin : g_tap
      if (TAPS[i]) begin : g_on
         assign tapped[i] = cur[i];
      end else begin : g_off
         assign tapped[i] = 1'b0;
      end
   end

   // The correction term steers top-only into zero and zero into the seed.
   assign low_clear = (cur[WIDTH-2:0] == '0);
   assign fb        = (^tapped) ^ low_clear;
   assign nxt       = {cur[WIDTH-2:0], fb};

endmodule

// File: rtl/epg_count_step.sv
module epg_count_step #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   assign nxt = cur + ONE;

endmodule

// File: rtl/epg_run_ctl.sv
module epg_run_ctl #(
   parameter int unsigned WIDTH = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic load,
   output logic advance,
   output logic running,
   output logic finished
);

   localparam logic [WIDTH-1:0] LAST = '1;
   localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

   logic [WIDTH-1:0] emitted_q;
   logic             run_q;
   logic             fin_q;
   logic             at_last;

   assign at_last = (emitted_q == LAST);
   assign load    = !run_q && start;
   assign advance = run_q && !at_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q     <= 1'b0;
         fin_q     <= 1'b0;
         emitted_q <= '0;
      end else begin
         fin_q <= 1'b0;
         if (load) begin
            run_q     <= 1'b1;
            emitted_q <= '0;
         end else if (run_q) begin
            if (at_last) begin
               run_q <= 1'b0;
               fin_q <= 1'b1;
            end else begin
               emitted_q <= emitted_q + ONE;
            end
         end
      end
   end

   assign running  = run_q;
   assign finished = fin_q;

endmodule

// File: rtl/exh_pattern_gen.sv
module exh_pattern_gen
   import epg_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             mode,
   output logic [WIDTH-1:0] pattern,
   output logic             valid,
   output logic             done
);

   if (WIDTH < EPG_MIN_W || WIDTH > EPG_MAX_W) begin : g_bad_width
      $error("exh_pattern_gen: WIDTH must lie in 3..24");
   end

   localparam logic [WIDTH-1:0] SEED_SHIFT = WIDTH'(1);
   localparam logic [WIDTH-1:0] SEED_COUNT = '0;

   logic [WIDTH-1:0] pat_q;
   logic [WIDTH-1:0] nxt_shift;
   logic [WIDTH-1:0] nxt_count;
   gen_mode_e        mode_q;
   gen_mode_e        mode_in;
   logic             load;
   logic             advance;
   logic             running;
   logic             finished;

   assign mode_in = gen_mode_e'(mode);

   epg_run_ctl #(.WIDTH(WIDTH)) u_ctl (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .load     (load),
      .advance  (advance),
      .running  (running),
      .finished (finished)
   );

   epg_shift_step #(.WIDTH(WIDTH)) u_shift (
      .cur (pat_q),
      .nxt (nxt_shift)
   );

   epg_count_step #(.WIDTH(WIDTH)) u_count (
      .cur (pat_q),
      .nxt (nxt_count)
   );

   always_ff @(posedge clk) begin
      if (rst || load) begin
         mode_q <= mode_in;
         pat_q  <= (mode_in == GEN_SHIFT) ? SEED_SHIFT : SEED_COUNT;
      end else if (advance) begin
         pat_q  <= (mode_q == GEN_SHIFT) ? nxt_shift : nxt_count;
      end
   end

   assign pattern = pat_q;
   assign valid   = running;
   assign done    = finished;

endmodule

// File: rtl/epg_chk.sv
module epg_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             start,
   input logic             shift_mode,
   input logic [WIDTH-1:0] pattern,
   input logic             valid,
   input logic             done
);

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> (!valid && !done));

   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (rst)
      (valid && !shift_mode) |=> (!valid || ((pattern - $past(pattern)) == WIDTH'(1))));

   // R4
   shift_step_chk: assert property (@(posedge clk) disable iff (rst)
      (valid && shift_mode) |=> (!valid || (pattern[WIDTH-1:1] == $past(pattern[WIDTH-2:0]))));

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R7
   done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
      (valid && !start) |=> (valid || done));

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> !valid);

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!valid && !start) |=> (pattern == $past(pattern)));

endmodule

bind exh_pattern_gen epg_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .start      (start),
   .shift_mode (mode_q),
   .pattern    (pattern),
   .valid      (valid),
   .done       (done)
);

// File: tb/exh_pattern_gen_tb.sv
module exh_pattern_gen_tb;

   localparam int unsigned W = 8;
   localparam int unsigned N = 1 << W;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic         mode = 1'b0;
   logic [W-1:0] pattern;
   logic         valid;
   logic         done;

   int n_checks = 0;
   int n_err    = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   exh_pattern_gen #(.WIDTH(W)) u_dut (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .mode    (mode),
      .pattern (pattern),
      .valid   (valid),
      .done    (done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic pulse_start(input logic m);
      @(negedge clk);
      mode  = m;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // After the last valid vector: done pulse, then idle hold.
   task automatic check_tail(input logic [W-1:0] last, input string req);
      chk(done == 1'b1, "R7", {req, " done after last"}, done, 1);
      chk(valid == 1'b0, "R7", {req, " valid low with done"}, valid, 0);
      chk(pattern == last, "R8", {req, " hold at done"}, pattern, last);
      @(negedge clk);
      chk(done == 1'b0, "R7", {req, " done one cycle"}, done, 0);
      mode = ~mode;
      repeat (4) @(negedge clk);
      chk(pattern == last && !valid, "R8", {req, " hold while idle"}, pattern, last);
   endtask

   task automatic t_reset();
      rst  = 1'b1;
      mode = 1'b1;
      repeat (2) @(negedge clk);
      chk(pattern == W'(1), "R1", "reset seed shift mode", pattern, 1);
      chk(!valid && !done, "R1", "reset idle shift mode", {valid, done}, 0);
      mode = 1'b0;
      @(negedge clk);
      chk(pattern == '0, "R1", "reset seed count mode", pattern, 0);
      chk(!valid && !done, "R1", "reset idle count mode", {valid, done}, 0);
      rst = 1'b0;
   endtask

   task automatic t_count_run();
      int bad = 0;
      int vcnt = 0;
      logic [W-1:0] last = '0;
      pulse_start(1'b0);
      chk(valid == 1'b1, "R2", "count valid after start", valid, 1);
      chk(pattern == '0, "R2", "count first vector", pattern, 0);
      for (int i = 0; i < int'(N); i++) begin
         if (valid) vcnt++;
         if (pattern != W'(i)) bad++;
         last = pattern;
         @(negedge clk);
      end
      chk(bad == 0, "R3", "count steps mismatching", bad, 0);
      chk(last == '1, "R3", "count last vector", last, N - 1);
      chk(vcnt == int'(N), "R6", "count valid cycles", vcnt, N);
      check_tail(last, "count");
   endtask

   task automatic t_shift_run();
      logic [N-1:0] seen = '0;
      int dup = 0;
      int bad_shift = 0;
      int vcnt = 0;
      logic [W-1:0] prev = '0;
      logic [W-1:0] before_zero = '0;
      logic [W-1:0] last = '0;
      pulse_start(1'b1);
      chk(valid == 1'b1, "R2", "shift valid after start", valid, 1);
      chk(pattern == W'(1), "R2", "shift first vector", pattern, 1);
      for (int i = 0; i < int'(N); i++) begin
         if (valid) vcnt++;
         if (i > 0 && pattern[W-1:1] != prev[W-2:0]) bad_shift++;
         if (seen[pattern]) dup++;
         seen[pattern] = 1'b1;
         if (i > 0 && pattern == '0) before_zero = prev;
         prev = pattern;
         last = pattern;
         @(negedge clk);
      end
      chk(bad_shift == 0, "R4", "shift steps mismatching", bad_shift, 0);
      chk(dup == 0, "R5", "repeated vectors", dup, 0);
      chk($countones(seen) == int'(N), "R5", "distinct vectors", $countones(seen), N);
      chk(last == '0, "R5", "zero is last vector", last, 0);
      chk(before_zero == {1'b1, {(W-1){1'b0}}}, "R5", "vector before zero",
          before_zero, N / 2);
      chk(vcnt == int'(N), "R6", "shift valid cycles", vcnt, N);
      check_tail(last, "shift");
   endtask

   task automatic t_disturb_run();
      int bad = 0;
      int vcnt = 0;
      logic [W-1:0] last = '0;
      pulse_start(1'b0);
      for (int i = 0; i < int'(N); i++) begin
         if (valid) vcnt++;
         if (pattern != W'(i)) bad++;
         last = pattern;
         if (i == 10) begin
            start = 1'b1;
            mode  = 1'b1;
         end
         if (i == 11) start = 1'b0;
         @(negedge clk);
      end
      chk(bad == 0, "R9", "vectors with start mid-run", bad, 0);
      chk(bad == 0, "R10", "vectors with mode change mid-run", bad, 0);
      chk(vcnt == int'(N), "R9", "run length with start mid-run", vcnt, N);
      check_tail(last, "disturb");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_count_run();
      t_shift_run();
      t_disturb_run();
      t_shift_run();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule